// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block drives a group of general-purpose pins. Software configures it through a small register bus. The registers hold the value each pin should drive, whether each pin is an output, whether it drives in open-drain style, which peripheral (if any) owns the pin, and which pins keep driving during power-down. For every pin the block combines these settings with live signals from two peripherals and a power-down input. From this it produces the pad output value and the pad output enable. It also synchronizes the pad input so software can read it back.

A pin owned by a peripheral takes its output value from that peripheral. Some pins are marked at build time as hardware-directed. On those pins an active peripheral may also switch the direction from cycle to cycle, for example to turn a shared bus around, with no software action. In open-drain mode a pin only ever pulls low. Writing a one releases the pad, so several pins can be joined as a wired-AND.

There is no state machine in this block. Its only sequential parts are the configuration registers and the input synchronizer. Everything else is combinational logic evaluated per pin.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero and no pad is driven (`pad_oe` is all zero).
- R2: A write takes effect on the clock edge that samples `reg_wr_en` high. The register map is: data latch 0x0, direction 0x1, open-drain 0x2, alternate-select 0 at 0x3, alternate-select 1 at 0x4, power-down keep 0x5, data-in 0x6 (read-only). Address 0x7 reads zero. `reg_rdata` shows the addressed register in the same cycle.
- R3: An open-drain pin (its open-drain bit is 1) whose resolved output value is 1 has `pad_oe` low. If the value is 0, the enable follows the pin's direction.
- R4: A push-pull pin (its open-drain bit is 0) has `pad_oe` equal to its effective direction, where 1 means output. `pad_out` always carries the resolved value.
- R5: While `pwr_down` is 1, `pad_oe` is 0 on every pin whose power-down keep bit is 0. Pins whose keep bit is 1 behave as usual.
- R6: When a pin's alternate-select 0 bit is 1, `pad_out` of that pin equals `alt0_out` of that pin.
- R7: When only a pin's alternate-select 1 bit is 1, `pad_out` equals `alt1_out`. When both bits are 1, alternate 0 wins.
- R8: On pins with index below `HW_DIR_FIRST`, the direction always comes from the direction register, even while an alternate function is selected.
- R9: On pins with index at or above `HW_DIR_FIRST`, the direction is `hw_dir_out` while an alternate function is selected and `hw_dir_valid` is 1. Otherwise the direction register applies.
- R10: Writing the data latch while a pin is an input sets that pin's `pad_out` with `pad_oe` still low. Enabling the output afterwards drives the preloaded value.
- R11: Data-in returns `pad_in` as sampled two clock edges earlier, whatever the direction. Writes to 0x6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data of the addressed register |
| pwr_down | input | 1 | Power-down request |
| alt0_out | input | NUM_PINS | Output values from alternate function 0 |
| alt1_out | input | NUM_PINS | Output values from alternate function 1 |
| hw_dir_out | input | NUM_PINS | Direction requested by the peripheral (1 = output) |
| hw_dir_valid | input | NUM_PINS | Peripheral direction request is valid |
| pad_in | input | NUM_PINS | Pad input sample |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
The bench builds the block with eight pins and `HW_DIR_FIRST` set to 4. The lower half of the port therefore follows software direction, and the upper half lets the peripheral take over direction. A single run can then set one alternate function across both kinds of pin and show the direction override on one half but not the other. The eight-pin width also leaves room for mixed patterns in one vector. In those patterns, open-drain, push-pull, power-down keep and alternate priority each affect different pins at the same time.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_LATCH  = 3'd0,
        RA_DIR    = 3'd1,
        RA_ODSEL  = 3'd2,
        RA_ALT0   = 3'd3,
        RA_ALT1   = 3'd4,
        RA_PDKEEP = 3'd5,
        RA_DIN    = 3'd6,
        RA_NONE   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_LATCH = 2'd0,
        SRC_ALT0  = 2'd1,
        SRC_ALT1  = 2'd2
    } out_src_e;

endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]   wdata,
    input  logic [NUM_PINS-1:0]   din,
    output logic [NUM_PINS-1:0]   rdata,
    output logic [NUM_PINS-1:0]   latch_q,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [NUM_PINS-1:0]   od_q,
    output logic [NUM_PINS-1:0]   alt0_q,
    output logic [NUM_PINS-1:0]   alt1_q,
    output logic [NUM_PINS-1:0]   pdkeep_q
);

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            dir_q    <= '0;
            od_q     <= '0;
            alt0_q   <= '0;
            alt1_q   <= '0;
            pdkeep_q <= '0;
        end else if (wr_en) begin
            case (addr_e)
                RA_LATCH:  latch_q  <= wdata;
                RA_DIR:    dir_q    <= wdata;
                RA_ODSEL:  od_q     <= wdata;
                RA_ALT0:   alt0_q   <= wdata;
                RA_ALT1:   alt1_q   <= wdata;
                RA_PDKEEP: pdkeep_q <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_e)
            RA_LATCH:  rdata = latch_q;
            RA_DIR:    rdata = dir_q;
            RA_ODSEL:  rdata = od_q;
            RA_ALT0:   rdata = alt0_q;
            RA_ALT1:   rdata = alt1_q;
            RA_PDKEEP: rdata = pdkeep_q;
            RA_DIN:    rdata = din;
            RA_NONE:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] d,
    output logic [NUM_PINS-1:0] q
);

    logic [NUM_PINS-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_port_pkg::*;
#(
    parameter bit HW_DIR = 1'b0
) (
    input  logic latch,
    input  logic dir,
    input  logic od,
    input  logic alt0_sel,
    input  logic alt1_sel,
    input  logic pdkeep,
    input  logic pwr_down,
    input  logic alt0_val,
    input  logic alt1_val,
    input  logic hw_dir,
    input  logic hw_dir_valid,
    output logic pad_out,
    output logic pad_oe
);

    out_src_e src;
    logic     value;
    logic     alt_on;
    logic     hw_take;
    logic     dir_eff;
    logic     od_release;
    logic     pd_block;

    // alternate 0 has priority over alternate 1
    always_comb begin
        if (alt0_sel)      src = SRC_ALT0;
        else if (alt1_sel) src = SRC_ALT1;
        else               src = SRC_LATCH;
    end

    always_comb begin
        unique case (src)
            SRC_ALT0: value = alt0_val;
            SRC_ALT1: value = alt1_val;
            default:  value = latch;
        endcase
    end

    assign alt_on     = alt0_sel | alt1_sel;
    assign hw_take    = HW_DIR & alt_on & hw_dir_valid;
    assign dir_eff    = hw_take ? hw_dir : dir;
    assign od_release = od & value;
    assign pd_block   = pwr_down & ~pdkeep;

    assign pad_out = value;
    assign pad_oe  = dir_eff & ~od_release & ~pd_block;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS     = 8,
    parameter int HW_DIR_FIRST = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [NUM_PINS-1:0]   reg_wdata,
    output logic [NUM_PINS-1:0]   reg_rdata,
    input  logic                  pwr_down,
    input  logic [NUM_PINS-1:0]   alt0_out,
    input  logic [NUM_PINS-1:0]   alt1_out,
    input  logic [NUM_PINS-1:0]   hw_dir_out,
    input  logic [NUM_PINS-1:0]   hw_dir_valid,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe
);

    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] od_q;
    logic [NUM_PINS-1:0] alt0_q;
    logic [NUM_PINS-1:0] alt1_q;
    logic [NUM_PINS-1:0] pdkeep_q;
    logic [NUM_PINS-1:0] din_q;

    gpio_in_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_q)
    );

    gpio_regbank #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .din      (din_q),
        .rdata    (reg_rdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .od_q     (od_q),
        .alt0_q   (alt0_q),
        .alt1_q   (alt1_q),
        .pdkeep_q (pdkeep_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam bit PIN_HW_DIR = (i >= HW_DIR_FIRST);
        gpio_pin_resolve #(
            .HW_DIR (PIN_HW_DIR)
        ) u_pin (
            .latch        (latch_q[i]),
            .dir          (dir_q[i]),
            .od           (od_q[i]),
            .alt0_sel     (alt0_q[i]),
            .alt1_sel     (alt1_q[i]),
            .pdkeep       (pdkeep_q[i]),
            .pwr_down     (pwr_down),
            .alt0_val     (alt0_out[i]),
            .alt1_val     (alt1_out[i]),
            .hw_dir       (hw_dir_out[i]),
            .hw_dir_valid (hw_dir_valid[i]),
            .pad_out      (pad_out[i]),
            .pad_oe       (pad_oe[i])
        );
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NUM_PINS     = 8,
    parameter int HW_DIR_FIRST = 4,
    parameter int SYNC_STAGES  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_en,
    input logic [2:0]          reg_addr,
    input logic [NUM_PINS-1:0] reg_wdata,
    input logic                pwr_down,
    input logic [NUM_PINS-1:0] alt0_out,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] latch_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] od_q,
    input logic [NUM_PINS-1:0] alt0_q,
    input logic [NUM_PINS-1:0] pdkeep_q,
    input logic [NUM_PINS-1:0] din_q
);

    localparam logic [NUM_PINS-1:0] SW_MASK =
        NUM_PINS'((64'd1 << HW_DIR_FIRST) - 64'd1);

    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_write_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 3'd0) |=> latch_q == $past(reg_wdata));

    p_write_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 3'd1) |=> dir_q == $past(reg_wdata));

    p_od_no_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q & pad_out & pad_oe) == '0);

    p_pd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (pad_oe & ~pdkeep_q) == '0);

    p_alt0_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & alt0_q) == (alt0_out & alt0_q));

    p_sw_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q & SW_MASK) == '0);

    p_sync_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_STAGES == 2 && cyc >= 2'd2) |-> din_q == $past(pad_in, 2));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .NUM_PINS     (NUM_PINS),
    .HW_DIR_FIRST (HW_DIR_FIRST),
    .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pwr_down  (pwr_down),
    .alt0_out  (alt0_out),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .alt0_q    (alt0_q),
    .pdkeep_q  (pdkeep_q),
    .din_q     (din_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;

    localparam int N   = 8;
    localparam int HWF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         pwr_down = 1'b0;
    logic [N-1:0] alt0_out = '0;
    logic [N-1:0] alt1_out = '0;
    logic [N-1:0] hw_dir_out = '0;
    logic [N-1:0] hw_dir_valid = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl #(.NUM_PINS(N), .HW_DIR_FIRST(HWF)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .pwr_down     (pwr_down),
        .alt0_out     (alt0_out),
        .alt1_out     (alt1_out),
        .hw_dir_out   (hw_dir_out),
        .hw_dir_valid (hw_dir_valid),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_reg [6];
    logic [N-1:0] hist [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) m_reg[k] = '0;
            hist = {};
            hist.push_front('0);
            hist.push_front('0);
        end else begin
            if (reg_wr_en && reg_addr < 3'd6) m_reg[reg_addr] = reg_wdata;
            hist.push_front(pad_in);
            while (hist.size() > 2) void'(hist.pop_back());
        end
    end

    function automatic logic [N-1:0] model_read(input logic [2:0] a);
        if (a < 3'd6)  return m_reg[a];
        if (a == 3'd6) return hist[1];
        return '0;
    endfunction

    function automatic void model_pads(output logic [N-1:0] o, output logic [N-1:0] e);
        for (int i = 0; i < N; i++) begin
            logic v;
            logic d;
            bit   alt_sel;
            alt_sel = m_reg[3][i] || m_reg[4][i];
            if (m_reg[3][i])      v = alt0_out[i];
            else if (m_reg[4][i]) v = alt1_out[i];
            else                  v = m_reg[0][i];
            d = m_reg[1][i];
            if (i >= HWF && alt_sel && hw_dir_valid[i]) d = hw_dir_out[i];
            o[i] = v;
            e[i] = d;
            if (m_reg[2][i] && v) e[i] = 1'b0;
            if (pwr_down && !m_reg[5][i]) e[i] = 1'b0;
        end
    endfunction

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] eo;
            logic [N-1:0] ee;
            model_pads(eo, ee);
            chk("R4/R6/R7 model pad_out", pad_out, eo);
            chk("R3/R5/R9 model pad_oe", pad_oe, ee);
            chk("R2/R11 model reg_rdata", reg_rdata, model_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        step();
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic look();
        @(negedge clk);
        #0.1;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        look();
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        for (int a = 0; a < 8; a++) begin
            step();
            reg_addr = 3'(a);
            look();
            chk("R1 reg read", reg_rdata, 8'h00);
        end

        // R10: preload the latch while input, then enable
        wr(3'd0, 8'h3C);
        look();
        chk("R10 pad_out preload", pad_out, 8'h3C);
        chk("R10 pad_oe still off", pad_oe, 8'h00);
        chk("R2 latch readback", reg_rdata, 8'h3C);
        wr(3'd1, 8'hFF);
        look();
        chk("R10 driven value", pad_out, 8'h3C);
        chk("R4 push-pull oe", pad_oe, 8'hFF);
        chk("R2 dir readback", reg_rdata, 8'hFF);

        // R3: open-drain on low nibble
        wr(3'd2, 8'h0F);
        look();
        chk("R3 open-drain oe", pad_oe, 8'hF3);
        wr(3'd2, 8'h00);
        look();
        chk("R4 back to push-pull", pad_oe, 8'hFF);

        // R5: power-down with keep bits
        wr(3'd5, 8'h81);
        step();
        pwr_down = 1'b1;
        look();
        chk("R5 power-down oe", pad_oe, 8'h81);
        step();
        pwr_down = 1'b0;
        look();
        chk("R5 power-down released", pad_oe, 8'hFF);
        wr(3'd5, 8'h00);

        // R6: alternate 0
        step();
        alt0_out = 8'h02;
        alt1_out = 8'h01;
        wr(3'd3, 8'h03);
        look();
        chk("R6 alt0 route", pad_out, 8'h3E);

        // R7: alternate 1 and priority
        wr(3'd4, 8'h06);
        look();
        chk("R7 alt1 route and alt0 priority", pad_out, 8'h3A);

        // R8: software pin ignores peripheral direction
        step();
        hw_dir_valid = 8'hFF;
        hw_dir_out   = 8'hFF;
        wr(3'd1, 8'hFE);
        look();
        chk("R8 sw pin keeps software dir", pad_oe, 8'hFE);

        // R9: hardware-directed pin
        wr(3'd3, 8'h13);
        wr(3'd1, 8'h00);
        look();
        chk("R9 hw dir output", pad_oe, 8'h10);
        step();
        hw_dir_out = 8'h00;
        look();
        chk("R9 hw dir input", pad_oe, 8'h00);
        step();
        hw_dir_out   = 8'hFF;
        hw_dir_valid = 8'h00;
        look();
        chk("R9 invalid request falls back", pad_oe, 8'h00);

        // R11: input synchronizer and read-only data-in
        step();
        pad_in   = 8'h5A;
        reg_addr = 3'd6;
        look();
        chk("R11 din before capture", reg_rdata, 8'h00);
        look();
        chk("R11 din after one edge", reg_rdata, 8'h00);
        look();
        chk("R11 din after two edges", reg_rdata, 8'h5A);
        wr(3'd6, 8'hFF);
        step();
        reg_addr = 3'd6;
        look();
        chk("R11 din write ignored", reg_rdata, 8'h5A);
        wr(3'd1, 8'hFF);
        step();
        reg_addr = 3'd6;
        look();
        chk("R11 din readable as output", reg_rdata, 8'h5A);
        step();
        reg_addr = 3'd7;
        look();
        chk("R2 unmapped reads zero", reg_rdata, 8'h00);

        repeat (4) step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule